// File: doc/BRIEF.md
# Integer Arithmetic Status Flag Generator

This block sits beside an integer ALU and turns the operands and result of one operation into status flags. It produces a 64-bit carry and a 32-bit carry, a 64-bit and a 32-bit signed overflow, a sticky summary-overflow bit, and a 4-bit condition field that records the sign class of the result. It holds all of these flags in registers between operations. The ALU that computes the result is not part of this block.

Carry is not taken from the adder. The block marks a carry when any operand, compared as an unsigned number, exceeds the result. It runs this comparison at full width and again on the low half. The operand list holds the first operand, which may be bitwise inverted, the second operand, and an immediate when the immediate is flagged valid.

Each flag group has its own enable. The instruction can also declare that it already wrote either carry bit itself, and that bit is then left alone. The summary-overflow bit is cleared only by reset or by an explicit clear strobe.

Top module: `arith_flag_gen`

## Requirements
- R1: After reset every output is 0: `ca`, `ca32`, `ov`, `ov32`, `so` and `cr_field`.
- R2: On an accepted operation with `carry_en`=1 and `done_mask[0]`=0, `ca` becomes 1 exactly when some operand in the list is unsigned-greater than `result`. The list is the first operand, `opnd_b`, and also `imm_data` when `imm_valid`=1.
- R3: On the same condition, using `done_mask[1]`=0 in place of `done_mask[0]`, `ca32` becomes 1 exactly when the low 32 bits of some listed operand are unsigned-greater than the low 32 bits of `result`.
- R4: `done_mask` bit 0 set keeps `ca` at its previous value. `done_mask` bit 1 set keeps `ca32` at its previous value. Each bit acts independently of the other.
- R5: With `carry_en`=0, `ca` and `ca32` keep their previous values.
- R6: `ov` is 1 when the first operand and `opnd_b` agree in bit 63 and `result` bit 63 differs from them. `ov32` applies the same rule to bit 31. The immediate never takes part.
- R7: `ov` and `ov32` update only when `ov_en` and `ov_ok` are both 1. Otherwise they hold.
- R8: On an overflow update, `so` becomes its old value OR the new `ov`, and it never clears by itself. `so_clr` forces `so` to 0 on the next edge and takes priority over any set in the same cycle.
- R9: With `rec_en`=1, `cr_field` becomes {result<0, result>0, result==0, so}, with bit 3 as the negative flag. The result is treated as signed 64-bit, and the `so` value used is the updated one. With `rec_en`=0, `cr_field` holds.
- R10: With `inv_a`=1, the first operand is `~opnd_a` in every carry and overflow evaluation.
- R11: Flags change only on the clock edge where `op_valid`=1, and the new values appear one cycle after that edge. The one exception is `so_clr`, which acts on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| opnd_a | input | 64 | First operand |
| inv_a | input | 1 | Invert first operand |
| opnd_b | input | 64 | Second operand |
| imm_valid | input | 1 | Immediate joins the operand list |
| imm_data | input | 64 | Immediate operand |
| result | input | 64 | ALU result |
| carry_en | input | 1 | Carry update enable |
| done_mask | input | 2 | Bit 0 blocks `ca`, bit 1 blocks `ca32` |
| ov_en | input | 1 | Overflow enable |
| ov_ok | input | 1 | Overflow control valid |
| rec_en | input | 1 | Condition field update enable |
| so_clr | input | 1 | Clear summary overflow |
| ca | output | 1 | Carry |
| ca32 | output | 1 | Low-half carry |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | Low-half overflow |
| so | output | 1 | Sticky summary overflow |
| cr_field | output | 4 | {neg, pos, zero, so} |

## Verification
The assertions assume that control inputs are meaningful only in a cycle with `op_valid` high. They also assume that `so_clr` may arrive at any time, including in the same cycle as an overflowing operation. The bench drives every input at the falling clock edge and holds it for one full cycle, so each operation is sampled exactly once. It returns `op_valid` low between operations, which lets the hold properties observe quiet cycles. Operand values are chosen so that the carry and overflow rules give different answers at 64 and 32 bits.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;
    typedef struct packed {
        logic       ca;
        logic       ca32;
        logic       ov;
        logic       ov32;
        logic       so;
        logic [3:0] cr;
    } flag_state_t;
endpackage

// File: rtl/afg_carry_cmp.sv
module afg_carry_cmp #(
    parameter int DATA_W  = 64,
    parameter int HALF_W  = 32,
    parameter int NUM_OPS = 3
) (
    input  logic [NUM_OPS-1:0][DATA_W-1:0] ops,
    input  logic [NUM_OPS-1:0]             op_use,
    input  logic [DATA_W-1:0]              res,
    output logic                           gt_full,
    output logic                           gt_half
);
    logic [NUM_OPS-1:0] gt_full_v;
    logic [NUM_OPS-1:0] gt_half_v;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cmp
        assign gt_full_v[i] = op_use[i] && (ops[i] > res);
        assign gt_half_v[i] = op_use[i] && (ops[i][HALF_W-1:0] > res[HALF_W-1:0]);
    end

    assign gt_full = |gt_full_v;
    assign gt_half = |gt_half_v;
endmodule

// File: rtl/afg_ovf_detect.sv
module afg_ovf_detect #(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic [DATA_W-1:0] res,
    output logic              ovf_full,
    output logic              ovf_half
);
    localparam int NPOS = 2;
    localparam int SIGN_POS [NPOS] = '{DATA_W-1, HALF_W-1};
    logic [NPOS-1:0] ovf_v;

    for (genvar k = 0; k < NPOS; k++) begin : g_sign
        assign ovf_v[k] = (x[SIGN_POS[k]] == y[SIGN_POS[k]]) &&
                          (res[SIGN_POS[k]] != x[SIGN_POS[k]]);
    end

    assign ovf_full = ovf_v[0];
    assign ovf_half = ovf_v[1];
endmodule

// File: rtl/arith_flag_gen.sv
module arith_flag_gen
    import arith_flag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic              inv_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              imm_valid,
    input  logic [DATA_W-1:0] imm_data,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_en,
    input  logic [1:0]        done_mask,
    input  logic              ov_en,
    input  logic              ov_ok,
    input  logic              rec_en,
    input  logic              so_clr,
    output logic              ca,
    output logic              ca32,
    output logic              ov,
    output logic              ov32,
    output logic              so,
    output logic [3:0]        cr_field
);
    localparam int NUM_OPS = 3;

    flag_state_t st_d, st_q;

    logic [DATA_W-1:0]              a_eff;
    logic [NUM_OPS-1:0][DATA_W-1:0] op_list;
    logic [NUM_OPS-1:0]             op_use;
    logic                           gt_full, gt_half;
    logic                           ovf_full, ovf_half;

    // R10: the first operand is inverted before any flag evaluation
    assign a_eff   = inv_a ? ~opnd_a : opnd_a;
    assign op_list = {imm_data, opnd_b, a_eff};
    assign op_use  = {imm_valid, 1'b1, 1'b1};

    afg_carry_cmp #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W),
        .NUM_OPS(NUM_OPS)
    ) cmp_i (
        .ops    (op_list),
        .op_use (op_use),
        .res    (result),
        .gt_full(gt_full),
        .gt_half(gt_half)
    );

    afg_ovf_detect #(
        .DATA_W(DATA_W),
        .HALF_W(HALF_W)
    ) ovf_i (
        .x       (a_eff),
        .y       (opnd_b),
        .res     (result),
        .ovf_full(ovf_full),
        .ovf_half(ovf_half)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            if (carry_en) begin
                if (!done_mask[0]) st_d.ca   = gt_full;
                if (!done_mask[1]) st_d.ca32 = gt_half;
            end
            if (ov_en && ov_ok) begin
                st_d.ov   = ovf_full;
                st_d.ov32 = ovf_half;
                st_d.so   = st_q.so | ovf_full;
            end
        end
        if (so_clr) st_d.so = 1'b0;
        if (op_valid && rec_en) begin
            st_d.cr = {result[DATA_W-1],
                       !result[DATA_W-1] && (result != '0),
                       (result == '0),
                       st_d.so};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ca       = st_q.ca;
    assign ca32     = st_q.ca32;
    assign ov       = st_q.ov;
    assign ov32     = st_q.ov32;
    assign so       = st_q.so;
    assign cr_field = st_q.cr;

    p_ca_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !carry_en) |=> ($stable(ca) && $stable(ca32)));

    p_mask_ca_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && carry_en && done_mask[0]) |=> $stable(ca));

    p_mask_ca32_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && carry_en && done_mask[1]) |=> $stable(ca32));

    p_ov_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && ov_en && ov_ok) |=> ($stable(ov) && $stable(ov32)));

    p_so_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (so && !so_clr) |=> so);

    p_so_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        so_clr |=> !so);

    p_cr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && rec_en) |=> $stable(cr_field));

    p_cr_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && rec_en) |=> ($countones(cr_field[3:1]) == 1));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !so_clr) |=> ($stable(ca) && $stable(ca32) && $stable(ov)
                                    && $stable(ov32) && $stable(so)
                                    && $stable(cr_field)));
endmodule

// File: tb/arith_flag_gen_tb_top.sv
module arith_flag_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] opnd_a = '0;
    logic        inv_a = 1'b0;
    logic [63:0] opnd_b = '0;
    logic        imm_valid = 1'b0;
    logic [63:0] imm_data = '0;
    logic [63:0] result = '0;
    logic        carry_en = 1'b0;
    logic [1:0]  done_mask = '0;
    logic        ov_en = 1'b0;
    logic        ov_ok = 1'b0;
    logic        rec_en = 1'b0;
    logic        so_clr = 1'b0;
    logic        ca, ca32, ov, ov32, so;
    logic [3:0]  cr_field;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    arith_flag_gen dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opnd_a(opnd_a),
        .inv_a(inv_a), .opnd_b(opnd_b), .imm_valid(imm_valid),
        .imm_data(imm_data), .result(result), .carry_en(carry_en),
        .done_mask(done_mask), .ov_en(ov_en), .ov_ok(ov_ok), .rec_en(rec_en),
        .so_clr(so_clr), .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so),
        .cr_field(cr_field)
    );

    typedef struct packed {
        logic        inv;
        logic [63:0] a;
        logic [63:0] b;
        logic        immv;
        logic [63:0] imm;
        logic [63:0] res;
        logic        e_ca;
        logic        e_ca32;
        logic        e_ov;
        logic        e_ov32;
        logic [3:0]  e_cr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'h1, 64'h2, 1'b0, 64'h0, 64'h3, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100},
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 64'h0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0010},
        '{1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1001},
        '{1'b0, 64'h0000_0000_7FFF_FFFF, 64'h1, 1'b0, 64'h0, 64'h0000_0000_8000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0100},
        '{1'b1, 64'h0, 64'h5, 1'b0, 64'h0, 64'h4, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0100},
        '{1'b0, 64'h2, 64'h3, 1'b1, 64'hA, 64'h5, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0100},
        '{1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 64'h0, 64'h0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0011},
        '{1'b0, 64'h0000_0001_0000_0000, 64'h0, 1'b0, 64'h0, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0100}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic ce, input logic [1:0] dm, input logic oe,
                           input logic ok, input logic re);
        carry_en = ce; done_mask = dm; ov_en = oe; ov_ok = ok; rec_en = re;
    endtask

    task automatic load(input logic inv, input logic [63:0] a, input logic [63:0] b,
                        input logic immv, input logic [63:0] imm, input logic [63:0] res);
        inv_a = inv; opnd_a = a; opnd_b = b; imm_valid = immv; imm_data = imm; result = res;
    endtask

    // one operation: driven at a falling edge, checked at the next falling edge
    task automatic fire(input logic clr);
        @(negedge clk);
        op_valid = 1'b1; so_clr = clr;
        @(negedge clk);
        op_valid = 1'b0; so_clr = 1'b0;
    endtask

    task automatic clear_so();
        @(negedge clk);
        so_clr = 1'b1;
        @(negedge clk);
        so_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ca", ca, 0); chk("R1 ca32", ca32, 0);
        chk("R1 ov", ov, 0); chk("R1 ov32", ov32, 0);
        chk("R1 so", so, 0); chk("R1 cr", cr_field, 0);
        rst_n = 1'b1;

        // vector table: R2 R3 R6 R9 R10
        set_ctl(1'b1, 2'b00, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < NV; i++) begin
            clear_so();
            load(VECS[i].inv, VECS[i].a, VECS[i].b, VECS[i].immv, VECS[i].imm, VECS[i].res);
            fire(1'b0);
            chk("R2 ca", ca, VECS[i].e_ca);
            chk("R3 ca32", ca32, VECS[i].e_ca32);
            chk("R6 ov", ov, VECS[i].e_ov);
            chk("R6 ov32", ov32, VECS[i].e_ov32);
            chk("R9 cr", cr_field, VECS[i].e_cr);
        end

        // R8: sticky SO across a non-overflow op
        clear_so();
        load(1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 64'h8000_0000_0000_0000);
        fire(1'b0);
        chk("R8 so set", so, 1);
        load(1'b0, 64'h1, 64'h2, 1'b0, 64'h0, 64'h3);
        fire(1'b0);
        chk("R8 so sticky", so, 1);
        chk("R6 ov cleared", ov, 0);
        chk("R9 cr so bit", cr_field, 4'b0101);
        clear_so();
        chk("R8 so clr", so, 0);

        // R8: clear wins over a simultaneous set
        load(1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 64'h8000_0000_0000_0000);
        fire(1'b1);
        chk("R8 clr priority so", so, 0);
        chk("R8 clr priority ov", ov, 1);
        chk("R8 clr priority cr", cr_field, 4'b1000);

        // R7: overflow gate needs both controls
        load(1'b0, 64'h1, 64'h2, 1'b0, 64'h0, 64'h3);
        fire(1'b0);
        chk("R7 ov base", ov, 0);
        set_ctl(1'b1, 2'b00, 1'b1, 1'b0, 1'b1);
        load(1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 64'h8000_0000_0000_0000);
        fire(1'b0);
        chk("R7 ov hold ok=0", ov, 0);
        chk("R7 so hold ok=0", so, 0);
        set_ctl(1'b1, 2'b00, 1'b0, 1'b1, 1'b1);
        fire(1'b0);
        chk("R7 ov hold en=0", ov, 0);

        // R4: done mask per bit
        set_ctl(1'b1, 2'b00, 1'b1, 1'b1, 1'b1);
        load(1'b0, 64'h1, 64'h2, 1'b0, 64'h0, 64'h3);
        fire(1'b0);
        set_ctl(1'b1, 2'b01, 1'b1, 1'b1, 1'b1);
        load(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 64'h0);
        fire(1'b0);
        chk("R4 ca blocked", ca, 0);
        chk("R4 ca32 free", ca32, 1);
        set_ctl(1'b1, 2'b10, 1'b1, 1'b1, 1'b1);
        load(1'b0, 64'h1, 64'h2, 1'b0, 64'h0, 64'h3);
        fire(1'b0);
        chk("R4 ca free", ca, 0);
        chk("R4 ca32 blocked", ca32, 1);

        // R5: carry disabled holds both
        set_ctl(1'b1, 2'b00, 1'b1, 1'b1, 1'b1);
        load(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 64'h0);
        fire(1'b0);
        set_ctl(1'b0, 2'b00, 1'b1, 1'b1, 1'b1);
        load(1'b0, 64'h1, 64'h2, 1'b0, 64'h0, 64'h3);
        fire(1'b0);
        chk("R5 ca hold", ca, 1);
        chk("R5 ca32 hold", ca32, 1);

        // R9: record disabled holds the field (currently positive)
        set_ctl(1'b1, 2'b00, 1'b1, 1'b1, 1'b0);
        load(1'b0, 64'h0, 64'h0, 1'b0, 64'h0, 64'h0);
        fire(1'b0);
        chk("R9 cr hold", cr_field, 4'b0100);

        // R11: no strobe, no change
        set_ctl(1'b1, 2'b00, 1'b1, 1'b1, 1'b1);
        load(1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 64'h8000_0000_0000_0000);
        @(negedge clk);
        @(negedge clk);
        chk("R11 ca idle", ca, 0);
        chk("R11 ov idle", ov, 0);
        chk("R11 cr idle", cr_field, 4'b0100);
        chk("R11 so idle", so, 0);

        finish_run();
    end
endmodule